// File: doc/BRIEF.md
# Mirrored Memory Address Mapper

This block places a 24-bit CPU address space onto one compact byte-wide storage array and services byte, halfword and word loads and stores against it. The space has three populated regions and one gap. The lowest megabyte is a ROM window whose image repeats every `ROM_SIZE` bytes. An extended low RAM runs linearly from 0x100000 up to `LOW_END`. A high window runs from `HIGH_START` to the top of the space. It holds internal RAM and peripheral space, and only the first 1 KiB of each 4 KiB page there is real storage.

The span between `LOW_END` and `HIGH_START` is unmapped. Any access that touches it raises a fault. A faulting access is sent to nowhere: it stores nothing and it loads zero.

Every byte lane of a multi-byte access is decoded on its own address. Values are little-endian. Results are registered, so they show one clock after the request is sampled.

The region limits are elaboration parameters. The defaults keep the array at 4 KiB: a 1 KiB ROM, 1 KiB of extended RAM and two high pages. A full-size map, such as a 32 KiB ROM with the low end at 0x200000, is reached by overriding the parameters.

Top module: `amap_mirror_mapper`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `accRdata` is 0 and `accFault` is 0.
- R2: Lane k of an access (k = 0..3) uses address (accAddr + k) modulo 2^24, and each lane is decoded independently. A word at 0xFFFFFE therefore touches 0xFFFFFE, 0xFFFFFF, 0x000000 and 0x000001.
- R3: Any address below 0x100000 selects the ROM window byte at (address mod ROM_SIZE). For example, 0x000010, 0x000410 and 0x0FFC10 all name one byte when ROM_SIZE is 0x400.
- R4: Addresses from 0x100000 to LOW_END-1 map linearly onto their own storage. This storage does not alias the ROM window.
- R5: In the high window, address bits 11:10 are ignored, so a 1 KiB block repeats across each 4 KiB page. The page at 0xFFE000 and the page at 0xFFF000 are separate storage.
- R6: If any active lane address lies in [LOW_END, HIGH_START), then `accFault` is 1 after the access and no byte is stored. If that access is a read, `accRdata` is 0. Both LOW_END and HIGH_START-1 are inside the hole; LOW_END-1 and HIGH_START are mapped.
- R7: The access is little-endian. Lane k carries `accWdata[8k+7:8k]` on a write and `accRdata[8k+7:8k]` on a read.
- R8: `accSize` encodes the access width as 0 = byte, 1 = halfword, and 2 or 3 = word. Reads are zero-extended. A byte write changes only one byte.
- R9: `accFault` is updated on every access and holds while `accEn` is 0. `accRdata` is updated only by reads and holds across idle cycles and across writes.
- R10: The results of a request sampled at a clock edge are visible right after that edge. A read issued on the cycle after a write to the same byte returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accEn | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAddr | input | 24 | Byte address of lane 0 |
| accSize | input | 2 | Access width code |
| accWdata | input | 32 | Store data, lane 0 in bits 7:0 |
| accRdata | output | 32 | Registered load data |
| accFault | output | 1 | Registered hole fault of the last access |

## Verification
The bench targets the region edges: LOW_END-1 against LOW_END, and HIGH_START-1 against HIGH_START. A decoder that is off by one at either edge would store into the hole or fault on a valid byte.

A word that straddles into the hole must leave its in-range bytes untouched. A design that gates writes per lane instead of per access would corrupt them.

A word at the very top of the space must wrap into the ROM window, and aliased addresses must read back the same byte. Carrying the lane sum past bit 23, or folding the wrong address bits, would make those reads miss.

Finally, the bench checks that a hole read returns zero even when the previous result was nonzero, and that writes leave the last read value in place.

// File: rtl/amap_pkg.sv
package amap_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } accSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [LANES-1:0] laneWr;   // per-lane store enable
    logic [LANES-1:0] laneAct;  // lane takes part in the access
    logic             rdEn;     // load this cycle
    logic             accEn;    // any access this cycle
    logic             fault;    // some active lane hit the hole
  } strobe_t;
endpackage

// File: rtl/amap_lane_decode.sv
module amap_lane_decode #(
  parameter int unsigned ROM_SIZE   = 32'h400,
  parameter int unsigned LOW_END    = 32'h10_0400,
  parameter int unsigned HIGH_START = 32'hFF_E000,
  parameter int unsigned IDX_W      = 12
) (
  input  logic [23:0]      addr,
  output logic [IDX_W-1:0] idx,
  output logic             hole
);
  localparam logic [31:0] MIRROR_TOP = 32'h0010_0000;
  localparam logic [31:0] HIGH_BASE  = ROM_SIZE + LOW_END - MIRROR_TOP;
  localparam bit          TWO_PAGES  = (HIGH_START == 32'hFF_E000);

  logic [31:0] a32;

  always_comb begin
    a32  = {8'h00, addr};
    hole = 1'b0;
    idx  = '0;
    if (a32 < LOW_END) begin
      if (a32 < MIRROR_TOP) idx = IDX_W'(a32 & (ROM_SIZE - 1));
      else                  idx = IDX_W'(a32 - MIRROR_TOP + ROM_SIZE);
    end else if (a32 >= HIGH_START) begin
      // Folding drops bits 11:10, so only the page bit and bits 9:0 survive.
      // Storage is packed: each page keeps only its 1 KiB block.
      idx = IDX_W'(HIGH_BASE + ((TWO_PAGES && addr[12]) ? 32'h400 : 32'h0)
                   + {22'h0, addr[9:0]});
    end else begin
      hole = 1'b1;  // index stays 0, but the control never enables this lane
    end
  end
endmodule

// File: rtl/amap_ctrl.sv
module amap_ctrl
  import amap_pkg::*;
#(
  parameter int unsigned ROM_SIZE   = 32'h400,
  parameter int unsigned LOW_END    = 32'h10_0400,
  parameter int unsigned HIGH_START = 32'hFF_E000,
  parameter int unsigned IDX_W      = 12
) (
  input  logic                        accEn,
  input  logic                        accWrite,
  input  logic [23:0]                 accAddr,
  input  logic [1:0]                  accSize,
  output strobe_t                     strb,
  output logic [LANES-1:0][IDX_W-1:0] laneIdx
);
  logic [LANES-1:0] laneHole;
  logic [LANES-1:0] laneAct;
  logic             anyHole;
  accSize_e         sizeCode;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [23:0] laneAddr;
    assign laneAddr = accAddr + 24'(i);  // wraps modulo 2^24
    amap_lane_decode #(
      .ROM_SIZE(ROM_SIZE), .LOW_END(LOW_END),
      .HIGH_START(HIGH_START), .IDX_W(IDX_W)
    ) u_dec (
      .addr(laneAddr),
      .idx (laneIdx[i]),
      .hole(laneHole[i])
    );
  end

  always_comb begin
    sizeCode = accSize_e'(accSize);
    case (sizeCode)
      SZ_BYTE: laneAct = 4'b0001;
      SZ_HALF: laneAct = 4'b0011;
      default: laneAct = 4'b1111;
    endcase
  end

  assign anyHole = |(laneHole & laneAct);

  always_comb begin
    strb.laneAct = laneAct;
    strb.accEn   = accEn;
    strb.fault   = accEn & anyHole;
    strb.rdEn    = accEn & ~accWrite;
    // A fault on any lane blocks the whole store.
    strb.laneWr  = {LANES{accEn & accWrite & ~anyHole}} & laneAct;
  end
endmodule

// File: rtl/amap_datapath.sv
module amap_datapath
  import amap_pkg::*;
#(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned IDX_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [LANES-1:0][IDX_W-1:0] laneIdx,
  input  logic [8*LANES-1:0]          wrData,
  output logic [8*LANES-1:0]          rdData,
  output logic                        fault
);
  logic [7:0]         mem [DEPTH];
  logic [8*LANES-1:0] rdNext;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (strb.laneWr[i]) mem[laneIdx[i]] <= wrData[8*i +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      rdNext[8*i +: 8] = strb.laneAct[i] ? mem[laneIdx[i]] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
      fault  <= 1'b0;
    end else if (strb.accEn) begin
      fault <= strb.fault;
      if (strb.rdEn) rdData <= strb.fault ? '0 : rdNext;
    end
  end
endmodule

// File: rtl/amap_mirror_mapper.sv
module amap_mirror_mapper
  import amap_pkg::*;
#(
  parameter int unsigned ROM_SIZE   = 32'h400,
  parameter int unsigned LOW_END    = 32'h10_0400,
  parameter int unsigned HIGH_START = 32'hFF_E000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        accEn,
  input  logic        accWrite,
  input  logic [23:0] accAddr,
  input  logic [1:0]  accSize,
  input  logic [31:0] accWdata,
  output logic [31:0] accRdata,
  output logic        accFault
);
  localparam int unsigned HIGH_PAGES = (32'h0100_0000 - HIGH_START) / 32'h1000;
  localparam int unsigned DEPTH      = ROM_SIZE + (LOW_END - 32'h0010_0000)
                                       + HIGH_PAGES * 32'h400;
  localparam int unsigned IDX_W      = $clog2(DEPTH);

  initial begin
    assert (LOW_END >= 32'h0010_0000)
      else $fatal(1, "LOW_END below 0x100000");
    assert (LOW_END <= HIGH_START)
      else $fatal(1, "LOW_END above HIGH_START");
    assert (ROM_SIZE != 0 && (ROM_SIZE & (ROM_SIZE - 1)) == 0 && ROM_SIZE <= 32'h0010_0000)
      else $fatal(1, "ROM_SIZE must be a power of two up to 1 MiB");
    assert (HIGH_START == 32'hFF_E000 || HIGH_START == 32'hFF_F000)
      else $fatal(1, "HIGH_START must be 0xFFE000 or 0xFFF000");
  end

  strobe_t                     strb;
  logic [LANES-1:0][IDX_W-1:0] laneIdx;

  amap_ctrl #(
    .ROM_SIZE(ROM_SIZE), .LOW_END(LOW_END),
    .HIGH_START(HIGH_START), .IDX_W(IDX_W)
  ) u_ctrl (
    .accEn   (accEn),
    .accWrite(accWrite),
    .accAddr (accAddr),
    .accSize (accSize),
    .strb    (strb),
    .laneIdx (laneIdx)
  );

  amap_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .laneIdx(laneIdx),
    .wrData (accWdata),
    .rdData (accRdata),
    .fault  (accFault)
  );
endmodule

// File: rtl/amap_checker.sv
module amap_checker #(
  parameter int unsigned LOW_END    = 32'h10_0400,
  parameter int unsigned HIGH_START = 32'hFF_E000
) (
  input logic        clk,
  input logic        rstN,
  input logic        accEn,
  input logic        accWrite,
  input logic [23:0] accAddr,
  input logic [1:0]  accSize,
  input logic [31:0] accRdata,
  input logic        accFault
);
  logic inHole;
  assign inHole = ({8'h00, accAddr} >= LOW_END) && ({8'h00, accAddr} < HIGH_START);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (accRdata == 32'h0 && !accFault));

  a_r6_hole_faults: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accSize == 2'd0 && inHole) |=> accFault);

  a_r3_mirror_never_faults: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accSize == 2'd0 && accAddr < 24'h10_0000) |=> !accFault);

  a_r6_fault_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWrite) |=> (!accFault || accRdata == 32'h0));

  a_r8_byte_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWrite && accSize == 2'd0) |=> accRdata[31:8] == 24'h0);

  a_r8_half_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && !accWrite && accSize == 2'd1) |=> accRdata[31:16] == 16'h0);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !accEn |=> ($stable(accRdata) && $stable(accFault)));

  a_r9_write_keeps_rdata: assert property (@(posedge clk) disable iff (!rstN)
    (accEn && accWrite) |=> $stable(accRdata));
endmodule

bind amap_mirror_mapper amap_checker #(
  .LOW_END(LOW_END), .HIGH_START(HIGH_START)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .accEn   (accEn),
  .accWrite(accWrite),
  .accAddr (accAddr),
  .accSize (accSize),
  .accRdata(accRdata),
  .accFault(accFault)
);

// File: tb/tb_amap_mirror_mapper.sv
module tb_amap_mirror_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accEn = 1'b0;
  logic        accWrite = 1'b0;
  logic [23:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic [31:0] accWdata = '0;
  logic [31:0] accRdata;
  logic        accFault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  amap_mirror_mapper dut (
    .clk(clk), .rstN(rstN), .accEn(accEn), .accWrite(accWrite),
    .accAddr(accAddr), .accSize(accSize), .accWdata(accWdata),
    .accRdata(accRdata), .accFault(accFault)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // One request; drive on falling edge, sample on the next falling edge.
  task automatic acc(input logic wr, input logic [23:0] a, input logic [1:0] sz,
                     input logic [31:0] wd);
    @(negedge clk);
    accEn = 1'b1; accWrite = wr; accAddr = a; accSize = sz; accWdata = wd;
    @(negedge clk);
    accEn = 1'b0; accWrite = 1'b0;
  endtask

  task automatic rd(input string req, input logic [23:0] a, input logic [1:0] sz,
                    input logic [31:0] expData, input logic expFault);
    acc(1'b0, a, sz, 32'h0);
    chk({req, " data"}, accRdata, expData);
    chk({req, " fault"}, {31'h0, accFault}, {31'h0, expFault});
  endtask

  task automatic t_reset;
    chk("R1 rdata", accRdata, 32'h0);
    chk("R1 fault", {31'h0, accFault}, 32'h0);
  endtask

  task automatic t_rom_alias;
    acc(1'b1, 24'h000010, 2'd0, 32'h5A);
    rd("R3 alias +0x400", 24'h000410, 2'd0, 32'h5A, 1'b0);
    rd("R3 alias 0x0FFC10", 24'h0FFC10, 2'd0, 32'h5A, 1'b0);
  endtask

  task automatic t_ext_low;
    acc(1'b1, 24'h100010, 2'd0, 32'hC3);
    rd("R4 ext byte", 24'h100010, 2'd0, 32'hC3, 1'b0);
    rd("R4 rom untouched", 24'h000010, 2'd0, 32'h5A, 1'b0);
    acc(1'b1, 24'h1003FF, 2'd0, 32'h77);
    acc(1'b1, 24'h1003FE, 2'd0, 32'h66);
    rd("R4 last byte below LOW_END", 24'h1003FF, 2'd0, 32'h77, 1'b0);
  endtask

  task automatic t_endian;
    acc(1'b1, 24'h100020, 2'd2, 32'h11223344);
    rd("R7 lane0", 24'h100020, 2'd0, 32'h44, 1'b0);
    rd("R7 lane1", 24'h100021, 2'd0, 32'h33, 1'b0);
    rd("R7 lane3", 24'h100023, 2'd0, 32'h11, 1'b0);
    rd("R7 half", 24'h100022, 2'd1, 32'h1122, 1'b0);
    rd("R7 word", 24'h100020, 2'd2, 32'h11223344, 1'b0);
    rd("R8 size code 3 is word", 24'h100020, 2'd3, 32'h11223344, 1'b0);
    acc(1'b1, 24'h100021, 2'd0, 32'hFFFFFFEE);
    rd("R8 byte write one byte", 24'h100020, 2'd2, 32'h1122EE44, 1'b0);
  endtask

  task automatic t_high_fold;
    acc(1'b1, 24'hFFF020, 2'd2, 32'hA1B2C3D4);
    rd("R5 fold 0xFFFC20", 24'hFFFC20, 2'd2, 32'hA1B2C3D4, 1'b0);
    rd("R5 fold 0xFFF420", 24'hFFF420, 2'd2, 32'hA1B2C3D4, 1'b0);
    acc(1'b1, 24'hFFE020, 2'd0, 32'h99);
    rd("R5 lower page fold", 24'hFFEC20, 2'd0, 32'h99, 1'b0);
    rd("R5 pages separate", 24'hFFF020, 2'd0, 32'hD4, 1'b0);
  endtask

  task automatic t_hole;
    rd("R6 read at LOW_END", 24'h100400, 2'd0, 32'h0, 1'b1);
    acc(1'b1, 24'hFFDFFF, 2'd0, 32'h12);
    chk("R6 write below HIGH_START faults", {31'h0, accFault}, 32'h1);
    rd("R6 HIGH_START mapped", 24'hFFE020, 2'd0, 32'h99, 1'b0);
    acc(1'b1, 24'h1003FE, 2'd2, 32'hDEADBEEF);
    chk("R6 straddle write faults", {31'h0, accFault}, 32'h1);
    rd("R6 straddle stored nothing", 24'h1003FE, 2'd1, 32'h7766, 1'b0);
    rd("R6 straddle read zero", 24'h1003FE, 2'd2, 32'h0, 1'b1);
  endtask

  task automatic t_wrap;
    acc(1'b1, 24'hFFFFFE, 2'd2, 32'h0D0C0B0A);
    rd("R2 lane0 in high page", 24'hFFF3FE, 2'd0, 32'h0A, 1'b0);
    rd("R2 lane1 in high page", 24'hFFFFFF, 2'd0, 32'h0B, 1'b0);
    rd("R2 lane2 wraps to rom", 24'h000400, 2'd0, 32'h0C, 1'b0);
    rd("R2 lane3 wraps to rom", 24'h000001, 2'd0, 32'h0D, 1'b0);
  endtask

  task automatic t_hold;
    rd("R9 setup read", 24'h100020, 2'd2, 32'h1122EE44, 1'b0);
    @(negedge clk);
    chk("R9 idle keeps rdata", accRdata, 32'h1122EE44);
    acc(1'b1, 24'h100030, 2'd0, 32'h01);
    chk("R9 write keeps rdata", accRdata, 32'h1122EE44);
    acc(1'b1, 24'h200000, 2'd0, 32'h02);
    @(negedge clk);
    chk("R9 idle keeps fault", {31'h0, accFault}, 32'h1);
    chk("R9 hole write keeps rdata", accRdata, 32'h1122EE44);
  endtask

  task automatic t_back2back;
    acc(1'b1, 24'h100100, 2'd0, 32'h3C);
    rd("R10 read right after write", 24'h100100, 2'd0, 32'h3C, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_rom_alias();
    t_ext_low();
    t_endian();
    t_high_fold();
    t_hole();
    t_wrap();
    t_hold();
    t_back2back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule